// File: doc/BRIEF.md
# Road-Matching Hit Filter

This block takes cluster centre positions, one per cycle, and decides which of them fall inside a set of position windows ("roads") that are loaded at the start of each event. Every stored road is compared against the incoming position in the same cycle. A position that lands inside at least one road is kept as a hit, tagged with the index of the road it matched. Positions that miss every road are dropped.

When the producer signals that the event's positions are complete, the channel asks for a readout bus that it shares with other channels. Once the bus is granted, the channel keeps it until it has sent a header word, each stored hit in arrival order, and a trailer word. Each of these words comes with its own single-cycle write strobe. A busy flag covers the whole event, from its start until the trailer has gone out.

Top module: `hit_filter`

## Requirements
- R1: After reset, `busy`, `bus_req`, `bus_hold`, `out_wr` and `road_err` are all 0, and `road_count` is 0.
- R2: `evt_start` empties the road table and the hit buffer, whatever state the block is in. While collecting, each `road_wr` places (`road_lo`, `road_hi`) at the next index, starting from 0, and `road_count` reports how many roads are stored.
- R3: Once `MAX_ROADS` roads are stored, any further `road_wr` leaves the table unchanged. It sets `road_err`, which stays at 1 until the next `evt_start`.
- R4: A centroid at position p matches road k when `lo[k] <= p <= hi[k]`; both bounds are inclusive. A centroid that matches no stored road produces no output word.
- R5: When several roads match, the hit records the lowest matching road index.
- R6: Hit words are sent in arrival order. Each has bits [W-1:W-2] = 2'b10, the road index in the IDX_W bits above the position, and the position in bits [POS_W-1:0].
- R7: The first word of a readout is the header: top bits 2'b01, `CHAN_ID` in bits [EVT_W+CHAN_W-1:EVT_W], and the event number latched at `evt_start` in bits [EVT_W-1:0]. The last word is the trailer: top bits 2'b11, the stored hit count in bits [HCNT_W-1:0], and the overflow flag in bit HCNT_W. All other bits are 0.
- R8: After `evt_done`, `bus_req` is 1 and `out_wr` is 0 until `bus_gnt` is seen. From the cycle after the grant, `bus_hold` is 1 for a run of consecutive cycles, and that run carries the whole packet.
- R9: A readout issues exactly one `out_wr` pulse per word, which is the stored hit count plus 2.
- R10: Once `HIT_DEPTH` hits are stored, further matching centroids are dropped and the trailer overflow bit is set to 1. The trailer count then equals `HIT_DEPTH`.
- R11: `busy` rises in the cycle after `evt_start` and falls in the cycle after the trailer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | Begin a new event (clears roads and hits) |
| evt_num | input | EVT_W | Event number latched at `evt_start` |
| road_wr | input | 1 | Append one road |
| road_lo | input | POS_W | Lower road bound (inclusive) |
| road_hi | input | POS_W | Upper road bound (inclusive) |
| cen_valid | input | 1 | Centroid present this cycle |
| cen_pos | input | POS_W | Centroid position |
| evt_done | input | 1 | No more centroids; request readout |
| bus_gnt | input | 1 | Readout bus granted to this channel |
| busy | output | 1 | Event in progress |
| road_err | output | 1 | Road table overrun this event |
| road_count | output | RCNT_W | Number of stored roads |
| bus_req | output | 1 | Requesting the shared bus |
| bus_hold | output | 1 | Holding the bus for the packet |
| out_wr | output | 1 | Write strobe, one per word |
| out_data | output | WORD_W | Header, hit or trailer word |

## Verification
The bench keeps `MAX_ROADS` at its full value of 46, so it fills the complete road table and then writes past the end of it. It uses a 12-bit position and an 8-entry hit buffer. With only 8 entries, an event with a single wide road overflows the buffer after a handful of centroids, which makes the drop rule and the trailer flag easy to reach. It also sets `CHAN_ID` to 5, so the header check can tell the channel field apart from zero.

// File: rtl/hitf_pkg.sv
package hitf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_REQ,
      ST_HDR,
      ST_HITS,
      ST_TRL
   } hitf_state_e;

   localparam logic [1:0] TAG_HDR = 2'b01;
   localparam logic [1:0] TAG_HIT = 2'b10;
   localparam logic [1:0] TAG_TRL = 2'b11;
endpackage

// File: rtl/hitf_road_table.sv
module hitf_road_table #(
   parameter int POS_W     = 16,
   parameter int MAX_ROADS = 46,
   localparam int IDX_W    = $clog2(MAX_ROADS),
   localparam int RCNT_W   = $clog2(MAX_ROADS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [POS_W-1:0]  wr_lo,
   input  logic [POS_W-1:0]  wr_hi,
   input  logic [POS_W-1:0]  cen_pos,
   output logic [RCNT_W-1:0] count,
   output logic              err,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx
);
   logic [POS_W-1:0] lo_q [MAX_ROADS];
   logic [POS_W-1:0] hi_q [MAX_ROADS];
   logic [MAX_ROADS-1:0] in_road;
   logic room;

   assign room = count < RCNT_W'(MAX_ROADS);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
         err   <= 1'b0;
      end else if (wr_en) begin
         if (room) count <= count + 1'b1;
         else      err   <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && room && !clr) begin
         lo_q[count[IDX_W-1:0]] <= wr_lo;
         hi_q[count[IDX_W-1:0]] <= wr_hi;
      end
   end

   for (genvar i = 0; i < MAX_ROADS; i++) begin : g_cmp
      assign in_road[i] = (RCNT_W'(i) < count) &&
                          (lo_q[i] <= cen_pos) && (cen_pos <= hi_q[i]);
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = MAX_ROADS - 1; i >= 0; i--) begin
         if (in_road[i]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   assert_road_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= RCNT_W'(MAX_ROADS));
   assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   assert_full_write_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && count == RCNT_W'(MAX_ROADS)) |=> (err && $stable(count)));
endmodule

// File: rtl/hitf_hit_store.sv
module hitf_hit_store #(
   parameter int HIT_W     = 22,
   parameter int HIT_DEPTH = 32,
   localparam int SLOT_W   = $clog2(HIT_DEPTH),
   localparam int HCNT_W   = $clog2(HIT_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [HIT_W-1:0]  wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [HIT_W-1:0]  rd_data,
   output logic [HCNT_W-1:0] count,
   output logic              ovf
);
   logic [HIT_W-1:0] mem_q [HIT_DEPTH];
   logic room;

   assign room    = count < HCNT_W'(HIT_DEPTH);
   assign rd_data = mem_q[rd_slot];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (wr_en) begin
         if (room) count <= count + 1'b1;
         else      ovf   <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && room && !clr) mem_q[count[SLOT_W-1:0]] <= wr_data;
   end

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= HCNT_W'(HIT_DEPTH));
   assert_ovf_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && count == HCNT_W'(HIT_DEPTH)) |=> ovf);
endmodule

// File: rtl/hit_filter.sv
module hit_filter
   import hitf_pkg::*;
#(
   parameter int POS_W     = 16,
   parameter int MAX_ROADS = 46,
   parameter int HIT_DEPTH = 32,
   parameter int EVT_W     = 8,
   parameter int CHAN_W    = 3,
   parameter int CHAN_ID   = 0,
   localparam int IDX_W    = $clog2(MAX_ROADS),
   localparam int RCNT_W   = $clog2(MAX_ROADS + 1),
   localparam int SLOT_W   = $clog2(HIT_DEPTH),
   localparam int HCNT_W   = $clog2(HIT_DEPTH + 1),
   localparam int HIT_W    = IDX_W + POS_W,
   localparam int WORD_W   = 2 + HIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_start,
   input  logic [EVT_W-1:0]  evt_num,
   input  logic              road_wr,
   input  logic [POS_W-1:0]  road_lo,
   input  logic [POS_W-1:0]  road_hi,
   input  logic              cen_valid,
   input  logic [POS_W-1:0]  cen_pos,
   input  logic              evt_done,
   input  logic              bus_gnt,
   output logic              busy,
   output logic              road_err,
   output logic [RCNT_W-1:0] road_count,
   output logic              bus_req,
   output logic              bus_hold,
   output logic              out_wr,
   output logic [WORD_W-1:0] out_data
);
   initial begin
      assert (MAX_ROADS >= 2 && HIT_DEPTH >= 2) else $error("depths must be at least 2");
      assert (WORD_W - 2 >= CHAN_W + EVT_W) else $error("header fields exceed word");
      assert (WORD_W - 2 >= HCNT_W + 1) else $error("trailer fields exceed word");
      assert (CHAN_ID < (1 << CHAN_W)) else $error("CHAN_ID exceeds CHAN_W");
   end

   hitf_state_e       state_q;
   logic [EVT_W-1:0]  evt_q;
   logic [SLOT_W-1:0] rd_q;
   logic              collecting;
   logic              match;
   logic [IDX_W-1:0]  match_idx;
   logic [HIT_W-1:0]  rd_hit;
   logic [HCNT_W-1:0] hit_count;
   logic              hit_ovf;

   assign collecting = (state_q == ST_COLLECT);

   hitf_road_table #(.POS_W(POS_W), .MAX_ROADS(MAX_ROADS)) u_roads (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (evt_start),
      .wr_en   (road_wr && collecting),
      .wr_lo   (road_lo),
      .wr_hi   (road_hi),
      .cen_pos (cen_pos),
      .count   (road_count),
      .err     (road_err),
      .hit     (match),
      .hit_idx (match_idx)
   );

   hitf_hit_store #(.HIT_W(HIT_W), .HIT_DEPTH(HIT_DEPTH)) u_hits (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (evt_start),
      .wr_en   (cen_valid && collecting && match),
      .wr_data ({match_idx, cen_pos}),
      .rd_slot (rd_q),
      .rd_data (rd_hit),
      .count   (hit_count),
      .ovf     (hit_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         evt_q   <= '0;
         rd_q    <= '0;
      end else if (evt_start) begin
         state_q <= ST_COLLECT;
         evt_q   <= evt_num;
      end else begin
         unique case (state_q)
            ST_IDLE:    ;
            ST_COLLECT: if (evt_done) state_q <= ST_REQ;
            ST_REQ:     if (bus_gnt) state_q <= ST_HDR;
            ST_HDR: begin
               rd_q    <= '0;
               state_q <= (hit_count == '0) ? ST_TRL : ST_HITS;
            end
            ST_HITS: begin
               if (rd_q == SLOT_W'(hit_count - 1'b1)) state_q <= ST_TRL;
               else                                   rd_q    <= rd_q + 1'b1;
            end
            ST_TRL:     state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign bus_req  = (state_q == ST_REQ);
   assign bus_hold = (state_q == ST_HDR) || (state_q == ST_HITS) || (state_q == ST_TRL);
   assign out_wr   = bus_hold;

   always_comb begin
      out_data = '0;
      unique case (state_q)
         ST_HDR: begin
            out_data[WORD_W-1 -: 2]  = TAG_HDR;
            out_data[EVT_W +: CHAN_W] = CHAN_W'(CHAN_ID);
            out_data[EVT_W-1:0]       = evt_q;
         end
         ST_HITS: out_data = {TAG_HIT, rd_hit};
         ST_TRL: begin
            out_data[WORD_W-1 -: 2] = TAG_TRL;
            out_data[HCNT_W]        = hit_ovf;
            out_data[HCNT_W-1:0]    = hit_count;
         end
         default: out_data = '0;
      endcase
   end

   assert_grant_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_hold) |-> ($past(bus_gnt) && $past(bus_req)));
   assert_hdr_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_hold) |-> (out_data[WORD_W-1 -: 2] == TAG_HDR));
   assert_trl_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_hold) && !$past(evt_start)) |-> ($past(out_data[WORD_W-1 -: 2]) == TAG_TRL));
   assert_busy_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req || out_wr) |-> busy);
endmodule

// File: tb/hit_filter_tb.sv
module hit_filter_tb;
   localparam int POS_W = 12, MAXR = 46, DEPTH = 8, EVT_W = 8, CHAN_W = 3, CID = 5;
   localparam int IDX_W = 6, RCNT_W = 6, HCNT_W = 4, WORD_W = 2 + IDX_W + POS_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic evt_start = 0, road_wr = 0, cen_valid = 0, evt_done = 0, bus_gnt = 0;
   logic [EVT_W-1:0] evt_num = '0;
   logic [POS_W-1:0] road_lo = '0, road_hi = '0, cen_pos = '0;
   logic busy, road_err, bus_req, bus_hold, out_wr;
   logic [RCNT_W-1:0] road_count;
   logic [WORD_W-1:0] out_data;

   int checks = 0, errors = 0;
   bit finished = 0;

   int m_lo [MAXR];
   int m_hi [MAXR];
   int m_n, e_n, m_evt;
   bit e_ovf, m_err;
   logic [WORD_W-1:0] e_hit [DEPTH];
   logic [WORD_W-1:0] got [64];
   int n_got;

   always #10 clk = ~clk;

   hit_filter #(.POS_W(POS_W), .MAX_ROADS(MAXR), .HIT_DEPTH(DEPTH), .EVT_W(EVT_W),
                .CHAN_W(CHAN_W), .CHAN_ID(CID)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_num(evt_num),
      .road_wr(road_wr), .road_lo(road_lo), .road_hi(road_hi),
      .cen_valid(cen_valid), .cen_pos(cen_pos), .evt_done(evt_done),
      .bus_gnt(bus_gnt), .busy(busy), .road_err(road_err), .road_count(road_count),
      .bus_req(bus_req), .bus_hold(bus_hold), .out_wr(out_wr), .out_data(out_data));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [WORD_W-1:0] mk_hdr(input int evt);
      logic [WORD_W-1:0] w = '0;
      w[WORD_W-1 -: 2] = 2'b01; w[EVT_W +: CHAN_W] = CHAN_W'(CID); w[EVT_W-1:0] = EVT_W'(evt);
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] mk_trl(input int cnt, input bit ovf);
      logic [WORD_W-1:0] w = '0;
      w[WORD_W-1 -: 2] = 2'b11; w[HCNT_W] = ovf; w[HCNT_W-1:0] = HCNT_W'(cnt);
      return w;
   endfunction

   function automatic int find_road(input int p);
      for (int k = 0; k < m_n; k++) if (m_lo[k] <= p && p <= m_hi[k]) return k;
      return -1;
   endfunction

   task automatic begin_evt(input int evt);
      @(negedge clk); evt_start = 1; evt_num = EVT_W'(evt);
      @(negedge clk); evt_start = 0;
      m_n = 0; e_n = 0; e_ovf = 0; m_err = 0; m_evt = evt;
   endtask

   task automatic add_road(input int lo, input int hi);
      road_wr = 1; road_lo = POS_W'(lo); road_hi = POS_W'(hi);
      @(negedge clk); road_wr = 0;
      if (m_n < MAXR) begin m_lo[m_n] = lo; m_hi[m_n] = hi; m_n++; end
      else m_err = 1;
   endtask

   task automatic add_cen(input int p);
      int k;
      cen_valid = 1; cen_pos = POS_W'(p);
      @(negedge clk); cen_valid = 0;
      k = find_road(p);
      if (k >= 0) begin
         if (e_n < DEPTH) begin
            e_hit[e_n] = {2'b10, IDX_W'(k), POS_W'(p)}; e_n++;
         end else e_ovf = 1;
      end
   endtask

   task automatic drain(input int delay, input string tag);
      int guard;
      check(road_count == RCNT_W'(m_n), "R2 road_count", road_count, m_n);
      check(road_err == m_err, "R3 road_err", road_err, m_err);
      evt_done = 1;
      @(negedge clk); evt_done = 0;
      for (int d = 0; d < delay; d++) begin
         check(bus_req && !out_wr && !bus_hold, "R8 wait for grant", {bus_req, out_wr}, 2'b10);
         @(negedge clk);
      end
      bus_gnt = 1;
      n_got = 0; guard = 0;
      @(negedge clk);
      while (guard < 40) begin
         if (out_wr) begin
            check(bus_hold, "R8 hold during word", bus_hold, 1);
            got[n_got] = out_data; n_got++;
            if (out_data[WORD_W-1 -: 2] == 2'b11) break;
         end else begin
            check(0, "R8 contiguous packet", out_wr, 1);
            break;
         end
         @(negedge clk); guard++;
      end
      bus_gnt = 0;
      check(n_got == e_n + 2, {"R9 word count ", tag}, n_got, e_n + 2);
      if (n_got > 0) check(got[0] == mk_hdr(m_evt), {"R7 header ", tag}, got[0], mk_hdr(m_evt));
      for (int i = 0; i < e_n && i + 1 < n_got; i++)
         check(got[i + 1] == e_hit[i], {"R6 hit word ", tag}, got[i + 1], e_hit[i]);
      if (n_got > 0)
         check(got[n_got - 1] == mk_trl(e_n, e_ovf), {"R7 trailer ", tag},
               got[n_got - 1], mk_trl(e_n, e_ovf));
      check(busy == 1'b1, "R11 busy during trailer", busy, 1);
      @(negedge clk);
      check(busy == 1'b0 && !bus_hold, "R11 busy drops after trailer", busy, 0);
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check(!busy && !bus_req && !bus_hold && !out_wr && !road_err && road_count == 0,
            "R1 reset state", {busy, bus_req, bus_hold, out_wr, road_err}, 0);
      rst_n = 1;

      // R4 R5 R6: inclusive bounds, overlap priority, misses
      begin_evt(8'h3C);
      check(busy, "R11 busy after start", busy, 1);
      add_road(100, 200); add_road(150, 300); add_road(500, 500);
      add_cen(100); add_cen(200); add_cen(99); add_cen(250); add_cen(301);
      add_cen(500); add_cen(160); add_cen(501);
      drain(3, "R4 R5 bounds and priority");

      // R2: empty road table drops everything
      begin_evt(8'h01);
      add_cen(0); add_cen(4095); add_cen(77);
      drain(0, "R2 no roads");

      // R3: table overrun ignored, flag set
      begin_evt(8'h02);
      check(!road_err, "R3 err cleared by start", road_err, 0);
      for (int i = 0; i < MAXR; i++) add_road(i * 10, i * 10 + 5);
      add_road(3000, 3100); add_road(3000, 3100);
      add_cen(3050); add_cen(455); add_cen(0); add_cen(6);
      drain(1, "R3 overrun");

      // R10: hit buffer overflow
      begin_evt(8'hA5);
      check(!road_err && road_count == 0, "R2 table cleared", road_count, 0);
      add_road(0, 4095);
      for (int i = 0; i < DEPTH + 3; i++) add_cen(i * 37);
      drain(2, "R10 overflow");

      // random events
      for (int ev = 0; ev < 24; ev++) begin
         int nr, nc, lo, k;
         begin_evt(ev + 16);
         nr = $urandom_range(MAXR, 1);
         for (int r = 0; r < nr; r++) begin
            lo = $urandom_range(4000, 0);
            add_road(lo, lo + $urandom_range(60, 0));
         end
         nc = $urandom_range(12, 0);
         for (int c = 0; c < nc; c++) begin
            if ($urandom_range(1, 0) == 1) add_cen($urandom_range(4095, 0));
            else begin
               k = $urandom_range(m_n - 1, 0);
               add_cen($urandom_range(m_hi[k], m_lo[k]));
            end
         end
         drain($urandom_range(4, 0), "R4 R6 random");
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog R11 actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule